// File: doc/BRIEF.md
# Ping-Pong DMA Buffer Selector

This block chooses which of two external memory buffers, A or B, a DMA channel uses next, separately for the transmit and the receive direction. Each direction keeps a next-buffer pointer and a busy flag. When the channel asks for a buffer and that direction is idle, the block grants the buffer named by the pointer, flips the pointer so the other buffer follows, and marks the direction busy. The busy flag stays set until the channel reports that the buffer is finished. A request that arrives while the direction is still busy is held off and not granted.

The transmit side also has an append mode. In this mode every transmit grant goes to buffer A, and the pointer is left as it was. A terminate command raises a reset-append flag. The mode stays in force until the channel reports that the leftover data has drained. At that point the flag and the mode both clear, and transmit goes back to alternating from where its pointer stood.

All state can be read as one status byte.

Top module: `pingpong_buf_sel`

## Requirements
- R1: After a synchronous reset the status byte is 0x00 and both grant outputs are low.
- R2: Buffer codes are 0 for A and 1 for B. Right after reset, the first grant in each direction is buffer A.
- R3: A request on an idle direction gives a one-cycle grant in the cycle after it is sampled. In that same cycle the busy bit is set (status bit 2 for transmit, bit 0 for receive) and the next-buffer bit is inverted (bit 3 for transmit, bit 1 for receive). Outside append mode, successive grants therefore alternate A, B, A.
- R4: A request on a busy direction is not granted, and the next-buffer bit does not change.
- R5: A done pulse clears that direction's busy bit. A done pulse on an idle direction changes nothing.
- R6: The two directions are independent. Requests made in the same cycle are both granted, and activity in one direction leaves the other direction's bits unchanged.
- R7: A start-append pulse, given outside append mode, sets status bit 4. While bit 4 is set, each granted transmit request uses buffer A and leaves bit 3 unchanged.
- R8: A terminate pulse while bit 4 is set sets status bit 6. A terminate pulse while bit 4 is clear is ignored.
- R9: A flush-done pulse while bit 6 is set clears both bit 6 and bit 4. A flush-done pulse while bit 6 is clear is ignored.
- R10: Status bit 5 holds the buffer code of the most recent transmit grant.
- R11: Status bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Transmit channel requests a buffer |
| tx_done | input | 1 | Transmit channel has finished its buffer |
| rx_req | input | 1 | Receive channel requests a buffer |
| rx_done | input | 1 | Receive channel has finished its buffer |
| app_start | input | 1 | Enter transmit append mode |
| app_term | input | 1 | Terminate-append command |
| app_flushed | input | 1 | Remaining append data has drained |
| tx_grant | output | 1 | One-cycle transmit grant |
| tx_grant_buf | output | 1 | Buffer of the latest transmit grant (0 = A, 1 = B) |
| rx_grant | output | 1 | One-cycle receive grant |
| rx_grant_buf | output | 1 | Buffer of the latest receive grant (0 = A, 1 = B) |
| status | output | 8 | Read-only status byte |

## Verification
Transmit requests are issued one at a time, each separated by a done pulse, so that the A/B alternation can be seen apart from the busy stall. Requests are then repeated with no done pulse in between, which shows whether a busy direction truly holds back both the grant and the pointer. Transmit and receive requests are also raised in the same cycle, which would expose any state shared between the two directions. The append sequence is run in order (stray terminate and flush first, then start, grants, terminate, a grant while terminating, flush). This separates the A-only locking from normal alternation and shows that the pointer resumes where it stood.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int NDIR   = 2;
  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
  localparam int ST_W   = 8;
  localparam logic BUF_A = 1'b0;
  localparam logic BUF_B = 1'b1;
  localparam int ST_RX_BUSY = 0;
  localparam int ST_RX_NEXT = 1;
  localparam int ST_TX_BUSY = 2;
  localparam int ST_TX_NEXT = 3;
  localparam int ST_APPEND  = 4;
  localparam int ST_TX_CUR  = 5;
  localparam int ST_RST_APP = 6;
  localparam int ST_RSVD    = 7;
endpackage

// File: rtl/pps_dir_track.sv
module pps_dir_track
  import pps_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic done,
  input  logic lock_a,
  output logic grant,
  output logic grant_buf,
  output logic nxt,
  output logic busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      grant     <= 1'b0;
      grant_buf <= BUF_A;
      nxt       <= BUF_A;
      busy      <= 1'b0;
    end else begin
      grant <= 1'b0;
      if (req && !busy) begin
        grant <= 1'b1;
        busy  <= 1'b1;
        if (lock_a) begin
          grant_buf <= BUF_A;
        end else begin
          grant_buf <= nxt;
          nxt       <= ~nxt;
        end
      end else if (done) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pps_append_ctl.sv
module pps_append_ctl (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic term,
  input  logic flushed,
  output logic app_on,
  output logic rst_app
);
  always_ff @(posedge clk) begin
    if (rst) begin
      app_on  <= 1'b0;
      rst_app <= 1'b0;
    end else if (rst_app) begin
      if (flushed) begin
        app_on  <= 1'b0;
        rst_app <= 1'b0;
      end
    end else if (app_on) begin
      if (term) rst_app <= 1'b1;
    end else if (start) begin
      app_on <= 1'b1;
    end
  end
endmodule

// File: rtl/pingpong_buf_sel.sv
module pingpong_buf_sel
  import pps_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_req,
  input  logic            tx_done,
  input  logic            rx_req,
  input  logic            rx_done,
  input  logic            app_start,
  input  logic            app_term,
  input  logic            app_flushed,
  output logic            tx_grant,
  output logic            tx_grant_buf,
  output logic            rx_grant,
  output logic            rx_grant_buf,
  output logic [ST_W-1:0] status
);
  logic [NDIR-1:0] req_v, done_v, lock_v, grant_v, gbuf_v, nxt_v, busy_v;
  logic app_on, rst_app;

  assign req_v[DIR_TX]  = tx_req;
  assign req_v[DIR_RX]  = rx_req;
  assign done_v[DIR_TX] = tx_done;
  assign done_v[DIR_RX] = rx_done;

  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      if (d == DIR_TX) begin : g_lock
        assign lock_v[d] = app_on;
      end else begin : g_free
        assign lock_v[d] = 1'b0;
      end
      pps_dir_track u_trk (
        .clk       (clk),
        .rst       (rst),
        .req       (req_v[d]),
        .done      (done_v[d]),
        .lock_a    (lock_v[d]),
        .grant     (grant_v[d]),
        .grant_buf (gbuf_v[d]),
        .nxt       (nxt_v[d]),
        .busy      (busy_v[d])
      );
    end
  endgenerate

  pps_append_ctl u_app (
    .clk     (clk),
    .rst     (rst),
    .start   (app_start),
    .term    (app_term),
    .flushed (app_flushed),
    .app_on  (app_on),
    .rst_app (rst_app)
  );

  assign tx_grant     = grant_v[DIR_TX];
  assign tx_grant_buf = gbuf_v[DIR_TX];
  assign rx_grant     = grant_v[DIR_RX];
  assign rx_grant_buf = gbuf_v[DIR_RX];

  always_comb begin
    status             = '0;
    status[ST_RX_BUSY] = busy_v[DIR_RX];
    status[ST_RX_NEXT] = nxt_v[DIR_RX];
    status[ST_TX_BUSY] = busy_v[DIR_TX];
    status[ST_TX_NEXT] = nxt_v[DIR_TX];
    status[ST_APPEND]  = app_on;
    status[ST_TX_CUR]  = gbuf_v[DIR_TX];
    status[ST_RST_APP] = rst_app;
    status[ST_RSVD]    = 1'b0;
  end
endmodule

// File: rtl/pingpong_buf_sel_chk.sv
module pingpong_buf_sel_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_req,
  input logic       rx_req,
  input logic       tx_grant,
  input logic       tx_grant_buf,
  input logic       rx_grant,
  input logic [7:0] status
);
  assert_tx_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_req && status[2]) |=> (!tx_grant && $stable(status[3])));
  assert_rx_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_req && status[0]) |=> (!rx_grant && $stable(status[1])));
  assert_tx_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !status[2] && !status[4]) |=>
      (tx_grant && status[2] && (status[3] != $past(status[3]))));
  assert_rx_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_req && !status[0]) |=> (rx_grant && status[0] && (status[1] != $past(status[1]))));
  assert_append_a_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !status[2] && status[4]) |=> (tx_grant && !tx_grant_buf && $stable(status[3])));
  assert_rstapp_in_append_R8: assert property (@(posedge clk) disable iff (rst)
    status[6] |-> status[4]);
  assert_cur_buf_R10: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> (status[5] == tx_grant_buf));
  assert_reserved_R11: assert property (@(posedge clk) disable iff (rst)
    !status[7]);
endmodule

bind pingpong_buf_sel pingpong_buf_sel_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_req       (tx_req),
  .rx_req       (rx_req),
  .tx_grant     (tx_grant),
  .tx_grant_buf (tx_grant_buf),
  .rx_grant     (rx_grant),
  .status       (status)
);

// File: tb/tb_pingpong_buf_sel.sv
`timescale 1ns/1ps
module tb_pingpong_buf_sel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_req = 0, tx_done = 0, rx_req = 0, rx_done = 0;
  logic app_start = 0, app_term = 0, app_flushed = 0;
  logic tx_grant, tx_grant_buf, rx_grant, rx_grant_buf;
  logic [7:0] status;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pingpong_buf_sel dut (
    .clk(clk), .rst(rst), .tx_req(tx_req), .tx_done(tx_done),
    .rx_req(rx_req), .rx_done(rx_done), .app_start(app_start),
    .app_term(app_term), .app_flushed(app_flushed),
    .tx_grant(tx_grant), .tx_grant_buf(tx_grant_buf),
    .rx_grant(rx_grant), .rx_grant_buf(rx_grant_buf), .status(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    tx_req = 0; tx_done = 0; rx_req = 0; rx_done = 0;
    app_start = 0; app_term = 0; app_flushed = 0;
  endtask

  task automatic t_reset();
    rst = 1; clear_in();
    tick(); tick();
    rst = 0;
    chk("R1 status", status, 8'h00);
    chk("R1 grants", {tx_grant, rx_grant}, 0);
    chk("R11 bit7", status[7], 0);
  endtask

  task automatic t_alternate();
    tx_req = 1; tick(); clear_in();
    chk("R2 first tx grant", tx_grant, 1);
    chk("R2 first tx buf A", tx_grant_buf, 0);
    chk("R3 status after grant A", status, 8'h0C);
    tick();
    chk("R3 grant one cycle", tx_grant, 0);
    tx_done = 1; tick(); clear_in();
    chk("R5 busy cleared", status, 8'h08);
    tx_req = 1; tick(); clear_in();
    chk("R3 second grant B", {tx_grant, tx_grant_buf}, 2'b11);
    chk("R10 cur B", status, 8'h24);
    tx_done = 1; tick(); clear_in();
    tx_req = 1; tick(); clear_in();
    chk("R3 third grant A", {tx_grant, tx_grant_buf}, 2'b10);
    chk("R10 cur A", status, 8'h0C);
  endtask

  task automatic t_stall();
    tx_req = 1; tick();
    chk("R4 no grant when busy", tx_grant, 0);
    chk("R4 pointer held", status, 8'h0C);
    tick(); clear_in();
    chk("R4 still stalled", {tx_grant, status}, 9'h00C);
    tx_done = 1; tick(); clear_in();
    chk("R5 done clears busy", status, 8'h08);
    tx_done = 1; tick(); clear_in();
    chk("R5 idle done ignored", status, 8'h08);
  endtask

  task automatic t_dirs();
    rx_req = 1; tick(); clear_in();
    chk("R2 first rx buf A", {rx_grant, rx_grant_buf}, 2'b10);
    chk("R6 rx only", status, 8'h0B);
    rx_done = 1; tx_req = 1; rx_req = 0; tick(); clear_in();
    chk("R6 tx grant B with rx done", {tx_grant, tx_grant_buf, rx_grant}, 3'b110);
    chk("R6 status mixed", status, 8'h26);
    tx_done = 1; tick(); clear_in();
    tx_req = 1; rx_req = 1; tick(); clear_in();
    chk("R6 both granted", {tx_grant, tx_grant_buf, rx_grant, rx_grant_buf}, 4'b1011);
    chk("R6 both busy", status, 8'h0D);
    tx_done = 1; rx_done = 1; tick(); clear_in();
    chk("R5 both idle", status, 8'h08);
  endtask

  task automatic t_append();
    app_term = 1; tick(); clear_in();
    chk("R8 term outside append ignored", status, 8'h08);
    app_flushed = 1; tick(); clear_in();
    chk("R9 flush without reset-append ignored", status, 8'h08);
    app_start = 1; tick(); clear_in();
    chk("R7 append on", status, 8'h18);
    for (int i = 0; i < 2; i++) begin
      tx_req = 1; tick(); clear_in();
      chk("R7 append grant A", {tx_grant, tx_grant_buf}, 2'b10);
      chk("R7 pointer held", status, 8'h1C);
      tx_done = 1; tick(); clear_in();
    end
    app_term = 1; tick(); clear_in();
    chk("R8 reset-append set", status, 8'h58);
    tx_req = 1; tick(); clear_in();
    chk("R7 grant A while terminating", {tx_grant, tx_grant_buf, status}, 10'h25C);
    tx_done = 1; tick(); clear_in();
    app_flushed = 1; tick(); clear_in();
    chk("R9 flush clears append", status, 8'h08);
    tx_req = 1; tick(); clear_in();
    chk("R9 alternation resumes B", {tx_grant, tx_grant_buf, status}, 10'h324);
    tx_done = 1; tick(); clear_in();
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_alternate();
    t_stall();
    t_dirs();
    t_append();
    chk("R11 bit7 at end", status[7], 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule